// File: doc/BRIEF.md
# Hysteretic Temperature-Stepped Fan Duty Controller

This block turns a stream of sampled 16-bit temperature codes into a fan drive signal with five duty steps: off, quarter, half, three-quarter and full. Between any two neighbouring steps there are two thresholds. One is an upper threshold that the temperature must exceed to move up. The other is a lower threshold that it must fall beneath to move back down. The gap between them stops the fan from toggling when the temperature sits near a boundary.

The drive signal comes from a PWM generator with a fixed period of `PERIOD` clocks. Its high time is a width in clock counts. An automatic step loads the width for the new step. Software may also write a width directly. Either way, a new width starts at the next period boundary.

Every automatic rise is reported at once with a temperature-increase pulse. A PWM-changed pulse follows after a programmable settling delay, so the fan speed can settle before anything judges it. An automatic fall and a software width write each report a PWM-changed pulse at once. While reset is asserted the output is held fully on, and after reset the controller starts at the full step.

Top module: `fan_step_ctrl`

## Requirements
- R1: While `rst` is high, `pwm_out` is 1. In the first cycle after release, `duty_level` is 4, `cur_width` equals `PERIOD`, and both event outputs are 0.
- R2: A sample with `temp_code` strictly greater than the upper threshold of the current step raises `duty_level` by one. The step encoding is 0 = 0 %, 1 = 25 %, 2 = 50 %, 3 = 75 % and 4 = 100 %. The upper threshold for entering step i+1 is `rise_thr[16*i +: 16]`. The same sample pulses `evt_temp_inc` for one cycle. Both results are visible in the cycle after the sampling edge.
- R3: A sample with `temp_code` strictly below the lower threshold for leaving the current step lowers `duty_level` by one. The lower threshold for dropping to step i is `fall_thr[16*i +: 16]`. The same sample pulses `evt_pwm_changed` in the cycle after the sampling edge and does not pulse `evt_temp_inc`.
- R4: A sample that lies between the two thresholds around the current step leaves `duty_level` unchanged. A sample exactly equal to either threshold also leaves it unchanged.
- R5: One sample moves `duty_level` by at most one step, however far the temperature lies beyond the thresholds.
- R6: After an automatic step, the active width becomes floor(step × `PERIOD` / 4). It takes effect at a period boundary and is seen on `cur_width` within two periods.
- R7: Over any whole number of periods, `pwm_out` is high for `cur_width` clocks out of every `PERIOD` clocks.
- R8: After an `evt_temp_inc` pulse ends, `evt_pwm_changed` pulses exactly `SETTLE_CYC` cycles later, unless something else intervenes.
- R9: A further rise during the settling wait restarts the wait. Only one delayed `evt_pwm_changed` pulse appears, `SETTLE_CYC` cycles after the last rise pulse ends.
- R10: A write on `sw_width_we` sets the pending width to `sw_width`, limited to `PERIOD`. It pulses `evt_pwm_changed` in the next cycle and does not change `duty_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; forces full drive |
| temp_valid | input | 1 | Qualifies a temperature sample |
| temp_code | input | TEMP_W | Raw unsigned temperature code |
| rise_thr | input | 4*TEMP_W | Upper thresholds; slice i is the threshold for entering step i+1 |
| fall_thr | input | 4*TEMP_W | Lower thresholds; slice i is the threshold for dropping to step i |
| sw_width_we | input | 1 | Software width write strobe |
| sw_width | input | CNT_W | Software width in clock counts |
| pwm_out | output | 1 | Fan drive signal |
| duty_level | output | 3 | Current step, 0 to 4 |
| cur_width | output | CNT_W | Width in force for the current period |
| evt_temp_inc | output | 1 | One-cycle pulse on an automatic rise |
| evt_pwm_changed | output | 1 | One-cycle pulse on a settled rise, a fall or a software write |

## Verification
The step and both immediate events come from registers loaded at the sampling edge. The bench drives a sample over one negative-to-negative clock interval and checks these results at the next falling edge. The delayed PWM-changed pulse is checked by counting falling edges after the rise pulse. The bench asserts that the pulse appears only at count `SETTLE_CYC`+1 and nowhere else in the window. Widths can only change at a period boundary whose phase the bench does not track. The bench therefore waits two full periods before it reads `cur_width`, then counts high cycles over exactly two periods.

// File: rtl/fan_step_pkg.sv
package fan_step_pkg;

    localparam int NUM_STEPS = 4;

    typedef enum logic [2:0] {
        DUTY_0   = 3'd0,
        DUTY_25  = 3'd1,
        DUTY_50  = 3'd2,
        DUTY_75  = 3'd3,
        DUTY_100 = 3'd4
    } duty_lvl_e;

    typedef struct packed {
        logic up;
        logic dn;
    } step_evt_t;

    // Width in clocks for a given step: floor(step * period / 4)
    function automatic logic [31:0] level_width(input duty_lvl_e lvl, input int unsigned period);
        return (32'(period) * 32'(lvl)) / 32'(NUM_STEPS);
    endfunction

endpackage

// File: rtl/fan_level_fsm.sv
module fan_level_fsm
    import fan_step_pkg::*;
#(
    parameter int TEMP_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        smp_valid,
    input  logic [TEMP_W-1:0]           smp_temp,
    input  logic [NUM_STEPS*TEMP_W-1:0] up_thr_flat,
    input  logic [NUM_STEPS*TEMP_W-1:0] dn_thr_flat,
    output duty_lvl_e                   lvl_q,
    output step_evt_t                   evt_q
);

    logic [TEMP_W-1:0] up_thr [NUM_STEPS];
    logic [TEMP_W-1:0] dn_thr [NUM_STEPS];

    for (genvar gi = 0; gi < NUM_STEPS; gi++) begin : g_unpack
        assign up_thr[gi] = up_thr_flat[gi*TEMP_W +: TEMP_W];
        assign dn_thr[gi] = dn_thr_flat[gi*TEMP_W +: TEMP_W];
    end

    duty_lvl_e lvl_d;
    step_evt_t evt_d;
    logic [1:0] up_idx;
    logic [1:0] dn_idx;

    always_comb begin
        up_idx = lvl_q[1:0];
        dn_idx = lvl_q[1:0] - 2'd1;
        lvl_d  = lvl_q;
        evt_d  = '0;
        if (smp_valid) begin
            if (lvl_q != DUTY_100 && smp_temp > up_thr[up_idx]) begin
                lvl_d    = duty_lvl_e'(3'(lvl_q) + 3'd1);
                evt_d.up = 1'b1;
            end else if (lvl_q != DUTY_0 && smp_temp < dn_thr[dn_idx]) begin
                lvl_d    = duty_lvl_e'(3'(lvl_q) - 3'd1);
                evt_d.dn = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= DUTY_100;
            evt_q <= '0;
        end else begin
            lvl_q <= lvl_d;
            evt_q <= evt_d;
        end
    end

    p_single_step_r5: assert property (@(posedge clk) disable iff (rst)
        (lvl_q != $past(lvl_q)) |->
            ((3'(lvl_q) == 3'($past(lvl_q)) + 3'd1) || (3'($past(lvl_q)) == 3'(lvl_q) + 3'd1)));

    p_up_event_r2: assert property (@(posedge clk) disable iff (rst)
        evt_q.up |-> (3'(lvl_q) == 3'($past(lvl_q)) + 3'd1));

    p_down_event_r3: assert property (@(posedge clk) disable iff (rst)
        evt_q.dn |-> (3'($past(lvl_q)) == 3'(lvl_q) + 3'd1));

    p_excl_events_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt_q.up, evt_q.dn}));

endmodule

// File: rtl/fan_settle_timer.sv
module fan_settle_timer #(
    parameter int SETTLE_CYC = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic fire
);

    localparam int TW = $clog2(SETTLE_CYC + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            fire <= 1'b0;
        end else begin
            fire <= (cnt == TW'(1)) && !start;
            if (start)
                cnt <= TW'(SETTLE_CYC);
            else if (cnt != '0)
                cnt <= cnt - TW'(1);
        end
    end

    p_settle_countdown_r8: assert property (@(posedge clk) disable iff (rst)
        (!start && cnt != '0) |=> (cnt == $past(cnt) - TW'(1)));

    p_settle_fire_idle_r9: assert property (@(posedge clk) disable iff (rst)
        fire |-> (cnt == '0));

endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
    parameter int PERIOD = 1000,
    parameter int CNT_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_auto,
    input  logic [CNT_W-1:0] auto_w,
    input  logic             sw_we,
    input  logic [CNT_W-1:0] sw_w,
    output logic             pwm_out,
    output logic [CNT_W-1:0] cur_width
);

    localparam logic [CNT_W-1:0] PER_W = CNT_W'(PERIOD);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] pcnt;
    logic [CNT_W-1:0] pend_w;
    logic [CNT_W-1:0] act_w;
    logic [CNT_W-1:0] sw_lim;
    logic             wrap;

    assign wrap   = (pcnt == LAST);
    assign sw_lim = (sw_w > PER_W) ? PER_W : sw_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt   <= '0;
            pend_w <= PER_W;
            act_w  <= PER_W;
        end else begin
            pcnt <= wrap ? '0 : pcnt + CNT_W'(1);
            if (load_auto)
                pend_w <= auto_w;
            else if (sw_we)
                pend_w <= sw_lim;
            if (wrap)
                act_w <= pend_w;
        end
    end

    assign pwm_out   = rst | (pcnt < act_w);
    assign cur_width = act_w;

    p_width_at_boundary_r6: assert property (@(posedge clk) disable iff (rst)
        (act_w != $past(act_w)) |-> ($past(pcnt) == LAST));

    p_width_bound_r10: assert property (@(posedge clk) disable iff (rst)
        (act_w <= PER_W) && (pend_w <= PER_W));

    p_phase_bound_r7: assert property (@(posedge clk) disable iff (rst)
        pcnt < PER_W);

endmodule

// File: rtl/fan_step_ctrl.sv
module fan_step_ctrl
    import fan_step_pkg::*;
#(
    parameter int PERIOD     = 1000,
    parameter int SETTLE_CYC = 100000,
    parameter int CNT_W      = 16,
    parameter int TEMP_W     = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        temp_valid,
    input  logic [TEMP_W-1:0]           temp_code,
    input  logic [NUM_STEPS*TEMP_W-1:0] rise_thr,
    input  logic [NUM_STEPS*TEMP_W-1:0] fall_thr,
    input  logic                        sw_width_we,
    input  logic [CNT_W-1:0]            sw_width,
    output logic                        pwm_out,
    output logic [2:0]                  duty_level,
    output logic [CNT_W-1:0]            cur_width,
    output logic                        evt_temp_inc,
    output logic                        evt_pwm_changed
);

    duty_lvl_e        lvl;
    step_evt_t        step_evt;
    logic             settle_fire;
    logic             sw_evt_q;
    logic [CNT_W-1:0] auto_w;

    fan_level_fsm #(.TEMP_W(TEMP_W)) u_level (
        .clk         (clk),
        .rst         (rst),
        .smp_valid   (temp_valid),
        .smp_temp    (temp_code),
        .up_thr_flat (rise_thr),
        .dn_thr_flat (fall_thr),
        .lvl_q       (lvl),
        .evt_q       (step_evt)
    );

    fan_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst   (rst),
        .start (step_evt.up),
        .fire  (settle_fire)
    );

    assign auto_w = CNT_W'(level_width(lvl, PERIOD));

    fan_pwm_gen #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_pwm (
        .clk       (clk),
        .rst       (rst),
        .load_auto (step_evt.up | step_evt.dn),
        .auto_w    (auto_w),
        .sw_we     (sw_width_we),
        .sw_w      (sw_width),
        .pwm_out   (pwm_out),
        .cur_width (cur_width)
    );

    always_ff @(posedge clk) begin
        if (rst) sw_evt_q <= 1'b0;
        else     sw_evt_q <= sw_width_we;
    end

    assign duty_level      = 3'(lvl);
    assign evt_temp_inc    = step_evt.up;
    assign evt_pwm_changed = settle_fire | sw_evt_q | step_evt.dn;

    p_sw_no_level_r10: assert property (@(posedge clk) disable iff (rst)
        (sw_width_we && !temp_valid) |=> $stable(duty_level));

    p_inc_not_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (duty_level < $past(duty_level)) |-> !evt_temp_inc);

endmodule

// File: tb/fan_step_ctrl_tb_top.sv
module fan_step_ctrl_tb_top;

    localparam int PER = 20;
    localparam int SET = 30;
    localparam int CW  = 16;
    localparam int TW  = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          temp_valid = 1'b0;
    logic [TW-1:0] temp_code = '0;
    logic [4*TW-1:0] rise_thr = {16'd4000, 16'd3000, 16'd2000, 16'd1000};
    logic [4*TW-1:0] fall_thr = {16'd3900, 16'd2900, 16'd1900, 16'd900};
    logic          sw_width_we = 1'b0;
    logic [CW-1:0] sw_width = '0;
    logic          pwm_out;
    logic [2:0]    duty_level;
    logic [CW-1:0] cur_width;
    logic          evt_temp_inc;
    logic          evt_pwm_changed;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fan_step_ctrl #(.PERIOD(PER), .SETTLE_CYC(SET), .CNT_W(CW), .TEMP_W(TW)) dut_i (
        .clk(clk), .rst(rst), .temp_valid(temp_valid), .temp_code(temp_code),
        .rise_thr(rise_thr), .fall_thr(fall_thr), .sw_width_we(sw_width_we),
        .sw_width(sw_width), .pwm_out(pwm_out), .duty_level(duty_level),
        .cur_width(cur_width), .evt_temp_inc(evt_temp_inc), .evt_pwm_changed(evt_pwm_changed)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int t);
        @(negedge clk);
        temp_code  = TW'(t);
        temp_valid = 1'b1;
        @(negedge clk);
        temp_valid = 1'b0;
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            h += int'(pwm_out);
        end
    endtask

    task automatic settle_watch(input string req, output int hits, output int at);
        hits = 0;
        at = -1;
        for (int k = 1; k <= SET + 2; k++) begin
            @(negedge clk);
            if (evt_pwm_changed) begin
                hits++;
                at = k;
            end
        end
    endtask

    task automatic t_reset;
        int h;
        rst = 1'b1;
        count_high(3, h);
        chk("R1 pwm held high in reset", h, 3);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 level after reset", duty_level, 4);
        chk("R1 width after reset", cur_width, PER);
        chk("R1 events after reset", {evt_temp_inc, evt_pwm_changed}, 0);
    endtask

    task automatic t_descend;
        int h;
        for (int e = 3; e >= 0; e--) begin
            send(0);
            chk("R3 level steps down", duty_level, e);
            chk("R3 pwm_changed on fall", evt_pwm_changed, 1);
            chk("R3 no temp_inc on fall", evt_temp_inc, 0);
        end
        repeat (2 * PER) @(negedge clk);
        chk("R6 width at step 0", cur_width, 0);
        count_high(2 * PER, h);
        chk("R7 high count at step 0", h, 0);
    endtask

    task automatic t_hyst;
        int hits, at, h;
        send(1000);
        chk("R4 equal to rise threshold holds", duty_level, 0);
        send(1001);
        chk("R2 level steps up", duty_level, 1);
        chk("R2 temp_inc pulse", evt_temp_inc, 1);
        settle_watch("R8", hits, at);
        chk("R8 single delayed pulse", hits, 1);
        chk("R8 delayed pulse position", at, SET + 1);
        repeat (2 * PER) @(negedge clk);
        chk("R6 width at step 1", cur_width, PER / 4);
        count_high(2 * PER, h);
        chk("R7 high count at step 1", h, 2 * (PER / 4));
        send(950);
        chk("R4 inside band holds", duty_level, 1);
        send(900);
        chk("R4 equal to fall threshold holds", duty_level, 1);
        send(899);
        chk("R3 below fall threshold", duty_level, 0);
    endtask

    task automatic t_climb;
        int hits, at, h, early;
        early = 0;
        for (int e = 1; e <= 4; e++) begin
            send(5000);
            chk("R5 one step per sample", duty_level, e);
            chk("R2 temp_inc per step", evt_temp_inc, 1);
            early += int'(evt_pwm_changed);
        end
        settle_watch("R9", hits, at);
        chk("R9 no early pulse", early, 0);
        chk("R9 single pulse after restarts", hits, 1);
        chk("R9 pulse after last rise", at, SET + 1);
        repeat (2 * PER) @(negedge clk);
        chk("R6 width at step 4", cur_width, PER);
        count_high(2 * PER, h);
        chk("R7 high count at step 4", h, 2 * PER);
    endtask

    task automatic t_sw;
        int h;
        @(negedge clk);
        sw_width = 16'd7;
        sw_width_we = 1'b1;
        @(negedge clk);
        sw_width_we = 1'b0;
        chk("R10 pwm_changed on write", evt_pwm_changed, 1);
        chk("R10 level unchanged by write", duty_level, 4);
        repeat (2 * PER) @(negedge clk);
        chk("R10 written width", cur_width, 7);
        count_high(2 * PER, h);
        chk("R7 high count for written width", h, 14);
        @(negedge clk);
        sw_width = 16'd50;
        sw_width_we = 1'b1;
        @(negedge clk);
        sw_width_we = 1'b0;
        repeat (2 * PER) @(negedge clk);
        chk("R10 width limited to period", cur_width, PER);
    endtask

    initial begin
        t_reset();
        t_descend();
        t_hyst();
        t_climb();
        t_sw();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule